// File: doc/BRIEF.md
# Sixteen-Bit Rotate and Rotate-Through-Carry Unit

This block computes the four rotate operations of an integer datapath on a 16-bit operand: plain rotate left, plain rotate right, rotate left through the carry flag and rotate right through the carry flag. The caller presents the operation select, the operand, an 8-bit count and the current carry flag. One clock later the block returns the rotated value, a write-enable for the destination, an enable for the flag update and the new carry and overflow flags.

Only carry and overflow are produced. Sign, zero, parity and auxiliary-carry flags are never touched by a rotate, so the caller must keep its stored copies. The two operation families reduce the count differently. Plain rotates take the count modulo 16 and have a flags-only case when the count is a nonzero multiple of 16. Rotates through carry treat carry and operand as one 17-bit ring and reduce the 5-bit masked count modulo 17.

Top module: `rot_unit`

## Requirements
- R1: The outputs are registered. Every output reflects the inputs sampled at the previous rising clock edge. After any edge at which the synchronous active-high `rst` is high, all outputs are zero.
- R2: `op_sel` encoding is 0 = rotate left, 1 = rotate right, 2 = rotate left through carry, 3 = rotate right through carry. A plain rotate with `count[3:0]` nonzero rotates by `count[3:0]` places and raises both `result_we` and `flags_we`.
- R3: A plain rotate with `count[3:0]` = 0 and `count[4]` = 1 gives `result_we` = 0 and `flags_we` = 1. `result` equals the operand, and the flags are derived from that unchanged operand.
- R4: A plain rotate with `count[4:0]` = 0 gives `result_we` = 0 and `flags_we` = 0. `count[7:5]` has no effect on any operation.
- R5: After a plain rotate left with `flags_we` = 1, `carry_out` = `result[0]` and `ovf_out` = `result[0]` XOR `result[15]`.
- R6: After a plain rotate right with `flags_we` = 1, `carry_out` = `result[15]` and `ovf_out` = `result[15]` XOR `result[14]`.
- R7: Rotates through carry use n = `count[4:0]` mod 17. When n = 0, both enables are 0. Otherwise both enables are 1.
- R8: Rotate left through carry by n rotates the 17-bit ring {carry_in, operand} left by n. `carry_out` is operand bit 16-n, and `ovf_out` = `carry_out` XOR `result[15]`.
- R9: Rotate right through carry by n places the old carry at result bit 16-n. `carry_out` is operand bit n-1, and `ovf_out` = `result[15]` XOR `result[14]`.
- R10: When `flags_we` = 0, `carry_out` equals `carry_in` and `ovf_out` is 0. When `result_we` = 0, `result` equals the operand.
- R11: For rotates through carry, the number of ones in {carry_out, result} equals the number in {carry_in, operand}. For a plain rotate that writes, the number of ones in the operand is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation select (R2 encoding) |
| opnd | input | 16 | Operand to rotate |
| count | input | 8 | Rotate count |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Rotated value |
| result_we | output | 1 | Destination must be written |
| flags_we | output | 1 | Carry and overflow must be updated |
| carry_out | output | 1 | New carry flag |
| ovf_out | output | 1 | New overflow flag |

## Verification
A wrong count reduction shows up one cycle later as a result that is shifted by the wrong number of places, or as a write strobe with the wrong value. The corner counts 16, 17, 31 and counts with only the high bits set expose this at once. A fault in the ring path, such as a carry that is lost or duplicated, changes the number of ones across {carry, result} on the very next cycle. A wrong flag tap shows up as a carry or overflow that disagrees with the result bits presented alongside it in the same cycle.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    ROT_L = 2'd0,
    ROT_R = 2'd1,
    RTC_L = 2'd2,
    RTC_R = 2'd3
  } rot_op_e;
endpackage

// File: rtl/rot_barrel_left.sv
// Left rotator built from log2 stages; each stage rotates by a power of two
// modulo the word width, so any amount below 2**AMT_W is handled.
module rot_barrel_left #(
  parameter int W     = 16,
  parameter int AMT_W = 4
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stg [0:AMT_W];

  assign stg[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = (1 << k) % W;
    if (SH == 0) begin : g_pass
      assign stg[k+1] = stg[k];
    end else begin : g_rot
      assign stg[k+1] = amt[k] ? ((stg[k] << SH) | (stg[k] >> (W - SH)))
                               : stg[k];
    end
  end

  assign dout = stg[AMT_W];
endmodule

// File: rtl/rot_count_reduce.sv
// Count reduction for both rotate families. The ring modulus is WIDTH+1;
// the masked count never reaches twice that, so one compare-and-subtract
// replaces a divider.
module rot_count_reduce #(
  parameter int WIDTH = 16,
  localparam int PW   = $clog2(WIDTH),
  localparam int CW   = PW + 1
) (
  input  logic [CW-1:0] cnt_lo,
  output logic [PW-1:0] plain_amt,
  output logic          plain_hi,
  output logic [CW-1:0] ring_amt
);
  localparam logic [CW-1:0] RING_MOD = CW'(WIDTH + 1);

  assign plain_amt = cnt_lo[PW-1:0];
  assign plain_hi  = cnt_lo[PW];
  assign ring_amt  = (cnt_lo >= RING_MOD) ? (cnt_lo - RING_MOD) : cnt_lo;
endmodule

// File: rtl/rot_unit.sv
module rot_unit #(
  parameter int WIDTH    = 16,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          op_sel,
  input  logic [WIDTH-1:0]    opnd,
  input  logic [CNT_IN_W-1:0] count,
  input  logic                carry_in,
  output logic [WIDTH-1:0]    result,
  output logic                result_we,
  output logic                flags_we,
  output logic                carry_out,
  output logic                ovf_out
);
  import rot_pkg::*;

  localparam int PW = $clog2(WIDTH);
  localparam int CW = PW + 1;
  localparam int RW = WIDTH + 1;

  rot_op_e       op;
  logic [PW-1:0] plain_amt;
  logic          plain_hi;
  logic [CW-1:0] ring_amt;
  logic [PW-1:0] plain_rot;
  logic [CW-1:0] ring_rot;
  logic [WIDTH-1:0] plain_out;
  logic [RW-1:0]    ring_out;
  logic             cnt_hi_unused;

  logic [WIDTH-1:0] res_d;
  logic             rwe_d, fwe_d, cf_d, of_d;

  assign op            = rot_op_e'(op_sel);
  assign cnt_hi_unused = ^count[CNT_IN_W-1:CW];

  rot_count_reduce #(.WIDTH(WIDTH)) u_cnt (
    .cnt_lo    (count[CW-1:0]),
    .plain_amt (plain_amt),
    .plain_hi  (plain_hi),
    .ring_amt  (ring_amt)
  );

  // A right rotation by k equals a left rotation by the complement modulo width.
  assign plain_rot = (op == ROT_R) ? (PW'(0) - plain_amt) : plain_amt;
  assign ring_rot  = (op == RTC_R && ring_amt != '0) ? (CW'(RW) - ring_amt)
                                                     : ring_amt;

  rot_barrel_left #(.W(WIDTH), .AMT_W(PW)) u_plain (
    .din  (opnd),
    .amt  (plain_rot),
    .dout (plain_out)
  );

  rot_barrel_left #(.W(RW), .AMT_W(CW)) u_ring (
    .din  ({carry_in, opnd}),
    .amt  (ring_rot),
    .dout (ring_out)
  );

  always_comb begin
    res_d = opnd;
    rwe_d = 1'b0;
    fwe_d = 1'b0;
    cf_d  = carry_in;
    of_d  = 1'b0;
    unique case (op)
      ROT_L, ROT_R: begin
        rwe_d = (plain_amt != '0);
        fwe_d = rwe_d | plain_hi;
        res_d = plain_out;
        if (fwe_d) begin
          if (op == ROT_L) begin
            cf_d = plain_out[0];
            of_d = plain_out[0] ^ plain_out[WIDTH-1];
          end else begin
            cf_d = plain_out[WIDTH-1];
            of_d = plain_out[WIDTH-1] ^ plain_out[WIDTH-2];
          end
        end
      end
      RTC_L, RTC_R: begin
        rwe_d = (ring_amt != '0);
        fwe_d = rwe_d;
        res_d = ring_out[WIDTH-1:0];
        cf_d  = ring_out[WIDTH];
        if (fwe_d) begin
          if (op == RTC_L) of_d = ring_out[WIDTH] ^ ring_out[WIDTH-1];
          else             of_d = ring_out[WIDTH-1] ^ ring_out[WIDTH-2];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_we  <= 1'b0;
      carry_out <= 1'b0;
      ovf_out   <= 1'b0;
    end else begin
      result    <= res_d;
      result_we <= rwe_d;
      flags_we  <= fwe_d;
      carry_out <= cf_d;
      ovf_out   <= of_d;
    end
  end
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
  parameter int WIDTH    = 16,
  parameter int CNT_IN_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          op_sel,
  input logic [WIDTH-1:0]    opnd,
  input logic [CNT_IN_W-1:0] count,
  input logic                carry_in,
  input logic [WIDTH-1:0]    result,
  input logic                result_we,
  input logic                flags_we,
  input logic                carry_out,
  input logic                ovf_out
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !result_we && !flags_we && !carry_out && !ovf_out));

  // R3
  a_r3_flags_only: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!op_sel[1]) && $past(count[4:0]) == 5'h10)
      |-> (!result_we && flags_we && result == $past(opnd)));

  // R4
  a_r4_plain_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!op_sel[1]) && $past(count[4:0]) == 5'h00)
      |-> (!result_we && !flags_we));

  // R5
  a_r5_rol_flags: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 2'd0 && flags_we)
      |-> (carry_out == result[0] && ovf_out == (result[0] ^ result[WIDTH-1])));

  // R6
  a_r6_ror_flags: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 2'd1 && flags_we)
      |-> (carry_out == result[WIDTH-1] && ovf_out == (result[WIDTH-1] ^ result[WIDTH-2])));

  // R8
  a_r8_rcl_ovf: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 2'd2 && flags_we)
      |-> (ovf_out == (carry_out ^ result[WIDTH-1])));

  // R9
  a_r9_rcr_ovf: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel) == 2'd3 && flags_we)
      |-> (ovf_out == (result[WIDTH-1] ^ result[WIDTH-2])));

  // R10
  a_r10_quiet_flags: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !flags_we) |-> (carry_out == $past(carry_in) && !ovf_out));

  a_r10_write_implies_flags: assert property (@(posedge clk) disable iff (rst)
    result_we |-> flags_we);

  // R11
  a_r11_ring_ones: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_sel[1]))
      |-> ($countones({carry_out, result}) == $past($countones({carry_in, opnd}))));

  a_r11_plain_ones: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!op_sel[1]) && result_we)
      |-> ($countones(result) == $past($countones(opnd))));
endmodule

bind rot_unit rot_unit_chk #(.WIDTH(WIDTH), .CNT_IN_W(CNT_IN_W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opnd(opnd), .count(count),
  .carry_in(carry_in), .result(result), .result_we(result_we),
  .flags_we(flags_we), .carry_out(carry_out), .ovf_out(ovf_out)
);

// File: tb/tb_rot_unit.sv
`timescale 1ns/1ps
module tb_rot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_sel = '0;
  logic [15:0] opnd = '0;
  logic [7:0]  count = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        result_we, flags_we, carry_out, ovf_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rot_unit dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd(opnd), .count(count),
    .carry_in(carry_in), .result(result), .result_we(result_we),
    .flags_we(flags_we), .carry_out(carry_out), .ovf_out(ovf_out)
  );

  // {op, operand, count, cin, exp result, exp rwe, exp fwe, exp cf, exp of}
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] a;
    logic [7:0]  c;
    logic        ci;
    logic [15:0] r;
    logic        rwe;
    logic        fwe;
    logic        cf;
    logic        of;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    {2'd0, 16'h8001, 8'h01, 1'b0, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 R5
    {2'd1, 16'h0001, 8'h01, 1'b0, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 R6
    {2'd0, 16'h1234, 8'h04, 1'b0, 16'h2341, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 R5
    {2'd1, 16'h1234, 8'h24, 1'b0, 16'h4123, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 R6
    {2'd0, 16'h8000, 8'h10, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b1}, // R3
    {2'd1, 16'h4000, 8'h30, 1'b0, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b1}, // R3
    {2'd0, 16'hABCD, 8'h20, 1'b1, 16'hABCD, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 R10
    {2'd2, 16'h8000, 8'h01, 1'b1, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1}, // R8
    {2'd3, 16'h0001, 8'h01, 1'b1, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1}, // R9
    {2'd2, 16'h1234, 8'h11, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    {2'd3, 16'h0000, 8'h20, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 R10
    {2'd2, 16'h0001, 8'h12, 1'b0, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 R8
    {2'd2, 16'h8000, 8'h10, 1'b0, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0}, // R8
    {2'd3, 16'h0003, 8'h1F, 1'b0, 16'h0018, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 R9
    {2'd3, 16'h0000, 8'h10, 1'b1, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0}, // R9
    {2'd0, 16'h0001, 8'hE1, 1'b0, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b0}  // R4
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2:       return "R5";
      1:          return "R6";
      3, 6, 15:   return "R4";
      4, 5:       return "R3";
      7, 12:      return "R8";
      8, 14:      return "R9";
      9, 10, 11, 13: return "R7";
      default:    return "R2";
    endcase
  endfunction

  // Expected outputs {result, rwe, fwe, cf, of} written from the requirements.
  function automatic logic [19:0] ref_out(logic [1:0] op, logic [15:0] a,
                                          logic [7:0] c, logic ci);
    logic [15:0] r;
    logic [16:0] ring;
    logic cf, of;
    int k;
    r = a;
    if (!op[1]) begin
      k = int'(c[3:0]);
      if (k == 0 && !c[4]) return {a, 1'b0, 1'b0, ci, 1'b0};
      for (int i = 0; i < 16; i++)
        r[i] = (op == 2'd0) ? a[(i - k + 16) % 16] : a[(i + k) % 16];
      if (op == 2'd0) begin cf = r[0];  of = r[0] ^ r[15]; end
      else            begin cf = r[15]; of = r[15] ^ r[14]; end
      return {r, (k != 0), 1'b1, cf, of};
    end
    k = int'(c[4:0]) % 17;
    if (k == 0) return {a, 1'b0, 1'b0, ci, 1'b0};
    ring = {ci, a};
    for (int i = 0; i < 16; i++)
      r[i] = (op == 2'd2) ? ring[(i - k + 17) % 17] : ring[(i + k) % 17];
    if (op == 2'd2) begin cf = a[16 - k]; of = cf ^ r[15]; end
    else            begin cf = a[k - 1];  of = r[15] ^ r[14]; end
    return {r, 1'b1, 1'b1, cf, of};
  endfunction

  task automatic check(string tag, logic [19:0] exp);
    logic [19:0] act;
    act = {result, result_we, flags_we, carry_out, ovf_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h cnt=%h ci=%b got res=%h rwe=%b fwe=%b cf=%b of=%b expected res=%h rwe=%b fwe=%b cf=%b of=%b",
               tag, op_sel, opnd, count, carry_in,
               act[19:4], act[3], act[2], act[1], act[0],
               exp[19:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [15:0] a, logic [7:0] c, logic ci);
    @(negedge clk);
    op_sel = op; opnd = a; count = c; carry_in = ci;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 20'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].c, VECS[i].ci);
      check(vec_tag(i), {VECS[i].r, VECS[i].rwe, VECS[i].fwe, VECS[i].cf, VECS[i].of});
    end

    // Sweep of every count for every operation (R2 R7 R11 via the model).
    for (int op = 0; op < 4; op++) begin
      for (int c = 0; c < 256; c++) begin
        logic [15:0] a;
        logic ci;
        a  = 16'(c * 16'h9E37 + op * 16'h1F3B) ^ 16'h5A5A;
        ci = c[0] ^ c[3];
        apply(2'(op), a, 8'(c), ci);
        check(op[1] ? "R11" : "R2", ref_out(2'(op), a, 8'(c), ci));
      end
    end

    // Reset in the middle of traffic clears the outputs (R1).
    @(negedge clk);
    op_sel = 2'd2; opnd = 16'hFFFF; count = 8'h03; carry_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1", 20'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", ref_out(2'd2, 16'hFFFF, 8'h03, 1'b1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule